// File: doc/BRIEF.md
# Peripheral Idle Handshake Controller

This block sits beside a peripheral on a simple register bus. It holds one small configuration word. The word selects how the peripheral answers idle requests from a power manager, whether the peripheral may ask to wake the system, whether the interface clock is gated when the bus is quiet, and a software reset bit that clears itself. From this word and a few status inputs, the block drives four outputs: an idle acknowledge, a wakeup request, a one-cycle local reset pulse and an enable for an external clock-gating cell.

Software writes the word through a single-register write/read port. The port has no address and no back-pressure: a write takes effect on the clock edge where `reg_wr_en` is high. Read data is combinational and valid in the same cycle that `reg_rd_en` is high.

The power manager raises `idle_req_i` and waits for `idle_ack_o`. The peripheral reports internal activity on `busy_i` and reports wake-worthy events on `periph_evt_i`. All handshake outputs are registered, except the clock enable, which follows the bus strobes in the same cycle.

Top module: `idle_hs_ctrl`

## Requirements
- R1: The configuration word uses these bit positions: bit 0 is auto-idle, bit 2 is wakeup enable, and bits 4:3 are the idle policy (0 = forced, 1 = never, 2 = activity-based, 3 = reserved). A read returns the value last written to these fields.
- R2: Bits 31:5 and bit 1 always read as 0, and writes to bits 31:5 are ignored. When `reg_rd_en` is low, `reg_rdata` is 0.
- R3: After reset, every field is 0, `idle_ack_o`, `wake_req_o` and `periph_rst_o` are low, and `iclk_en_o` is high.
- R4: With policy 0, `idle_ack_o` is high in the cycle after a cycle in which `idle_req_i` is high, whatever the value of `busy_i`.
- R5: With policy 1 or policy 3, `idle_ack_o` never asserts.
- R6: With policy 2, `idle_ack_o` is high in the cycle after a cycle in which `idle_req_i` is high and `busy_i` is low. It goes low in the cycle after `busy_i` rises, even while the request stays high.
- R7: `idle_ack_o` is low in the cycle after a cycle in which `idle_req_i` is low.
- R8: Writing 1 to bit 1 drives `periph_rst_o` high for exactly one cycle: the cycle right after the write.
- R9: At the end of the reset pulse cycle, all fields return to 0. A write that arrives during the pulse cycle is discarded.
- R10: When auto-idle is 0, `iclk_en_o` is high. When auto-idle is 1, `iclk_en_o` is high only in cycles where `reg_wr_en` or `reg_rd_en` is high.
- R11: `wake_req_o` rises in the cycle after a cycle in which `idle_ack_o`, wakeup enable and `periph_evt_i` are all high. It then stays high until the cycle after `idle_req_i` goes low.
- R12: When wakeup enable is 0, `wake_req_o` is low in the next cycle. An event that arrives while `idle_ack_o` is low raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the configuration word |
| reg_rd_en | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rd_en` is high |
| idle_req_i | input | 1 | Idle request from the power manager |
| busy_i | input | 1 | The peripheral has internal activity |
| periph_evt_i | input | 1 | Peripheral wake event |
| idle_ack_o | output | 1 | Idle acknowledge |
| wake_req_o | output | 1 | Wakeup request |
| periph_rst_o | output | 1 | One-cycle local reset pulse |
| iclk_en_o | output | 1 | Interface clock enable for an external gating cell |

## Verification
The bench drives each idle policy with the peripheral both busy and quiet. A decoder that treated policy 3 as forced would acknowledge where it must not, and a smart-idle path that latched the acknowledge would keep it high after activity resumes. The reset pulse is probed cycle by cycle, with a write placed inside the pulse: a pulse that lasts two cycles, a bit that reads back as 1, or a write that survives the pulse would each show at the port. The wakeup path is tested with the enable off, with an event during a refused request and with the request withdrawn, which catches a wakeup that never clears or that fires without an acknowledge.

// File: rtl/idle_hs_pkg.sv
package idle_hs_pkg;

  // Idle policy encoding held in the configuration word
  typedef enum logic [1:0] {
    IDLE_FORCE = 2'd0,
    IDLE_NEVER = 2'd1,
    IDLE_SMART = 2'd2,
    IDLE_RSVD  = 2'd3
  } idle_pol_e;

  // Field positions seen by software
  localparam int AUTO_BIT   = 0;
  localparam int SRST_BIT   = 1;
  localparam int WAKE_BIT   = 2;
  localparam int MODE_LSB   = 3;
  localparam int MODE_W     = 2;
  localparam int CFG_USED_W = MODE_LSB + MODE_W;

  typedef struct packed {
    idle_pol_e mode;
    logic      wake_en;
    logic      auto_idle;
  } cfg_t;

endpackage

// File: rtl/idle_hs_cfg_reg.sv
module idle_hs_cfg_reg
  import idle_hs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output cfg_t              cfg,
  output logic              srst_pulse
);

  // Upper write bits carry no state
  logic unused_wbits;
  assign unused_wbits = ^wdata[DATA_W-1:CFG_USED_W];

  // The pulse cycle has priority: it clears the fields and swallows any write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= '0;
      srst_pulse <= 1'b0;
    end else if (srst_pulse) begin
      cfg        <= '0;
      srst_pulse <= 1'b0;
    end else if (wr_en) begin
      cfg.auto_idle <= wdata[AUTO_BIT];
      cfg.wake_en   <= wdata[WAKE_BIT];
      cfg.mode      <= idle_pol_e'(wdata[MODE_LSB +: MODE_W]);
      srst_pulse    <= wdata[SRST_BIT];
    end
  end

  // Reset bit and reserved bits always read back as zero
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      rdata[AUTO_BIT]             = cfg.auto_idle;
      rdata[WAKE_BIT]             = cfg.wake_en;
      rdata[MODE_LSB +: MODE_W]   = cfg.mode;
    end
  end

endmodule

// File: rtl/idle_hs_ack.sv
module idle_hs_ack
  import idle_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle_req,
  input  logic      busy,
  input  logic      evt,
  input  idle_pol_e mode,
  input  logic      wake_en,
  output logic      ack,
  output logic      wake
);

  logic ack_nxt;
  logic wake_nxt;

  // Policy decode; the reserved code behaves like never
  always_comb begin
    ack_nxt = 1'b0;
    if (idle_req) begin
      unique case (mode)
        IDLE_FORCE: ack_nxt = 1'b1;
        IDLE_SMART: ack_nxt = !busy;
        IDLE_NEVER,
        IDLE_RSVD:  ack_nxt = 1'b0;
        default:    ack_nxt = 1'b0;
      endcase
    end
  end

  // Wakeup is armed only while acknowledged; it holds until the request drops
  assign wake_nxt = idle_req && wake_en && (wake || (ack && evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack  <= 1'b0;
      wake <= 1'b0;
    end else begin
      ack  <= ack_nxt;
      wake <= wake_nxt;
    end
  end

endmodule

// File: rtl/idle_hs_clk_ctl.sv
module idle_hs_clk_ctl (
  input  logic auto_idle,
  input  logic bus_wr,
  input  logic bus_rd,
  output logic clk_en
);

  // Free-running unless autogating is selected; then on only for an access
  assign clk_en = !auto_idle || bus_wr || bus_rd;

endmodule

// File: rtl/idle_hs_ctrl.sv
module idle_hs_ctrl
  import idle_hs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              idle_req_i,
  input  logic              busy_i,
  input  logic              periph_evt_i,
  output logic              idle_ack_o,
  output logic              wake_req_o,
  output logic              periph_rst_o,
  output logic              iclk_en_o
);

  cfg_t cfg_q;

  idle_hs_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .rd_en      (reg_rd_en),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .cfg        (cfg_q),
    .srst_pulse (periph_rst_o)
  );

  idle_hs_ack u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle_req (idle_req_i),
    .busy     (busy_i),
    .evt      (periph_evt_i),
    .mode     (cfg_q.mode),
    .wake_en  (cfg_q.wake_en),
    .ack      (idle_ack_o),
    .wake     (wake_req_o)
  );

  idle_hs_clk_ctl u_clk (
    .auto_idle (cfg_q.auto_idle),
    .bus_wr    (reg_wr_en),
    .bus_rd    (reg_rd_en),
    .clk_en    (iclk_en_o)
  );

endmodule

// File: rtl/idle_hs_chk.sv
module idle_hs_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              idle_req_i,
  input logic              busy_i,
  input logic              periph_evt_i,
  input logic              idle_ack_o,
  input logic              wake_req_o,
  input logic              periph_rst_o,
  input logic              iclk_en_o,
  input logic [1:0]        mode,
  input logic              wake_en,
  input logic              auto_idle
);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |-> (reg_rdata[DATA_W-1:5] == '0 && reg_rdata[1] == 1'b0));

  // R4
  force_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req_i && mode == 2'd0) |=> idle_ack_o);

  // R5
  never_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 || mode == 2'd3) |=> !idle_ack_o);

  // R6
  smart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && busy_i) |=> !idle_ack_o);

  // R6
  smart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && idle_req_i && !busy_i) |=> idle_ack_o);

  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req_i |=> !idle_ack_o);

  // R8
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_o |=> !periph_rst_o);

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_o |=> (mode == 2'd0 && !wake_en && !auto_idle));

  // R10
  gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_idle && !reg_wr_en && !reg_rd_en) |-> !iclk_en_o);

  // R10
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_idle |-> iclk_en_o);

  // R11
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req_o) |-> $past(idle_ack_o && periph_evt_i && wake_en));

  // R11
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req_o && idle_req_i && wake_en) |=> wake_req_o);

  // R12
  wake_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_en |=> !wake_req_o);

endmodule

bind idle_hs_ctrl idle_hs_chk #(.DATA_W(DATA_W)) u_idle_hs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_rd_en    (reg_rd_en),
  .reg_rdata    (reg_rdata),
  .idle_req_i   (idle_req_i),
  .busy_i       (busy_i),
  .periph_evt_i (periph_evt_i),
  .idle_ack_o   (idle_ack_o),
  .wake_req_o   (wake_req_o),
  .periph_rst_o (periph_rst_o),
  .iclk_en_o    (iclk_en_o),
  .mode         (cfg_q.mode),
  .wake_en      (cfg_q.wake_en),
  .auto_idle    (cfg_q.auto_idle)
);

// File: tb/tb_idle_hs_ctrl.sv
`timescale 1ns/1ps
module tb_idle_hs_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        idle_req_i = 1'b0;
  logic        busy_i = 1'b0;
  logic        periph_evt_i = 1'b0;
  logic        idle_ack_o;
  logic        wake_req_o;
  logic        periph_rst_o;
  logic        iclk_en_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  idle_hs_ctrl dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_rd_en    (reg_rd_en),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .idle_req_i   (idle_req_i),
    .busy_i       (busy_i),
    .periph_evt_i (periph_evt_i),
    .idle_ack_o   (idle_ack_o),
    .wake_req_o   (wake_req_o),
    .periph_rst_o (periph_rst_o),
    .iclk_en_o    (iclk_en_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr_en = 1'b1;
    reg_wdata = d;
    tick();
    reg_wr_en = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic rd(output logic [31:0] d);
    reg_rd_en = 1'b1;
    #1;
    d = reg_rdata;
    reg_rd_en = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(v);
    chk("R3 cfg", v, 32'h0);
    chk("R3 ack", {31'b0, idle_ack_o}, 0);
    chk("R3 wake", {31'b0, wake_req_o}, 0);
    chk("R3 rst", {31'b0, periph_rst_o}, 0);
    chk("R3 clken", {31'b0, iclk_en_o}, 1);
    chk("R2 idle rdata", reg_rdata, 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(32'hFFFF_FFFD);
    rd(v);
    chk("R1 R2 fields all ones", v, 32'h1D);
    wr(32'h0000_0014);
    rd(v);
    chk("R1 wake+smart", v, 32'h14);
    wr(32'hFFFF_FFE0);
    rd(v);
    chk("R2 reserved only", v, 32'h0);
  endtask

  task automatic t_force();
    wr(32'h0);
    idle_req_i = 1'b1;
    busy_i = 1'b1;
    tick();
    chk("R4 ack busy", {31'b0, idle_ack_o}, 1);
    busy_i = 1'b0;
    tick();
    chk("R4 ack quiet", {31'b0, idle_ack_o}, 1);
    idle_req_i = 1'b0;
    tick();
    chk("R7 drop", {31'b0, idle_ack_o}, 0);
  endtask

  task automatic t_never(input logic [31:0] d);
    wr(d);
    idle_req_i = 1'b1;
    busy_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 no ack", {31'b0, idle_ack_o}, 0);
    end
    idle_req_i = 1'b0;
    tick();
  endtask

  task automatic t_smart();
    wr(32'h10);
    idle_req_i = 1'b1;
    busy_i = 1'b1;
    tick();
    chk("R6 busy hold off", {31'b0, idle_ack_o}, 0);
    busy_i = 1'b0;
    tick();
    chk("R6 quiet ack", {31'b0, idle_ack_o}, 1);
    busy_i = 1'b1;
    tick();
    chk("R6 resume drops", {31'b0, idle_ack_o}, 0);
    busy_i = 1'b0;
    tick();
    chk("R6 re-ack", {31'b0, idle_ack_o}, 1);
    idle_req_i = 1'b0;
    tick();
    chk("R7 drop smart", {31'b0, idle_ack_o}, 0);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    wr(32'h1F);
    chk("R8 pulse high", {31'b0, periph_rst_o}, 1);
    rd(v);
    chk("R8 bit reads 0", v, 32'h1D);
    wr(32'h04);
    chk("R8 pulse one cycle", {31'b0, periph_rst_o}, 0);
    rd(v);
    chk("R9 cleared, write dropped", v, 32'h0);
    tick();
    chk("R8 no second pulse", {31'b0, periph_rst_o}, 0);
  endtask

  task automatic t_clk();
    wr(32'h01);
    #1;
    chk("R10 gated idle", {31'b0, iclk_en_o}, 0);
    reg_rd_en = 1'b1;
    #1;
    chk("R10 on for read", {31'b0, iclk_en_o}, 1);
    reg_rd_en = 1'b0;
    reg_wr_en = 1'b1;
    reg_wdata = 32'h0;
    #1;
    chk("R10 on for write", {31'b0, iclk_en_o}, 1);
    tick();
    reg_wr_en = 1'b0;
    #1;
    chk("R10 free running", {31'b0, iclk_en_o}, 1);
  endtask

  task automatic t_wake();
    wr(32'h04);
    idle_req_i = 1'b1;
    tick();
    chk("R11 ack first", {31'b0, wake_req_o}, 0);
    periph_evt_i = 1'b1;
    tick();
    periph_evt_i = 1'b0;
    chk("R11 wake set", {31'b0, wake_req_o}, 1);
    tick();
    tick();
    chk("R11 wake held", {31'b0, wake_req_o}, 1);
    idle_req_i = 1'b0;
    tick();
    chk("R11 wake cleared", {31'b0, wake_req_o}, 0);
  endtask

  task automatic t_wake_off();
    wr(32'h00);
    idle_req_i = 1'b1;
    tick();
    periph_evt_i = 1'b1;
    tick();
    periph_evt_i = 1'b0;
    chk("R12 disabled", {31'b0, wake_req_o}, 0);
    idle_req_i = 1'b0;
    tick();
    wr(32'h0C);
    idle_req_i = 1'b1;
    periph_evt_i = 1'b1;
    tick();
    tick();
    periph_evt_i = 1'b0;
    chk("R12 no ack no wake", {31'b0, wake_req_o}, 0);
    idle_req_i = 1'b0;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_fields();
    t_force();
    t_never(32'h08);
    t_never(32'h18);
    t_smart();
    t_srst();
    t_clk();
    t_wake();
    t_wake_off();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule